// File: doc/BRIEF.md
# Periodic Broadcast Read Scheduler

This block decides when one collection channel sends a broadcast read command to its slaves. Software writes a control byte and an 8-bit delay value. The block then launches broadcasts in one of two ways: on a fixed repeating period, or once for each manual request. Both kinds of launch wait the same programmable pre-launch delay, which counts DELAY × DLY_STEP ticks of the timing enable.

Each launch is marked by a single-cycle strobe. The same strobe opens a sequence of capture windows, one per slave slot, in slot order 0 to NUM_SLOTS-1. Every slot is flagged as awaiting its response until its window has passed. A separate clear code wipes the channel back to its reset state. Collection can only be switched off by that clear code.

Top module: `pbs_brc_scheduler`

## Requirements
- R1: After reset, brc_launch, slot_win, slot_pend, st_en, st_auto and st_manual are all 0.
- R2: A control write with bit 0 set turns collection on (st_en). A control write with bit 0 clear never turns it off. A clear write with code 0xFF returns every output and field to its reset value. Any other clear code has no effect.
- R3: Control bit 1 (automatic mode) takes the written value only if collection was already on before that write. Otherwise the write leaves st_auto unchanged.
- R4: Control bit 7 (manual request) is accepted only if collection is on and the automatic-mode value after the write is 0. An accepted request shows on st_manual from the write until the cycle its launch strobe appears, and then clears by itself.
- R5: With tick held high, a manual launch strobe appears 5·D+1 clock edges after the accepting write edge, where D is the delay value written with it.
- R6: A manual request accepted while a launch is already pending is merged into that launch. No second launch follows.
- R7: Once automatic mode turns on, the first launch comes PERIOD_TICKS+5·D+1 edges later. Later launches are spaced exactly PERIOD_TICKS edges apart. Turning automatic mode off stops them.
- R8: brc_launch is high for exactly one cycle per launch.
- R9: In the launch cycle, slot_win is 0001 and slot_pend is 1111. Slot k's window lasts SLOT_TICKS ticks, then the window passes to slot k+1 and pending bit k clears. After the last slot, both buses are 0.
- R10: The delay, period and window counters advance only on cycles where tick is high.
- R11: A 0xFF clear cancels a pending launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing enable, one pulse per 0.1 µs step |
| cfg_wr | input | 1 | Control/delay write strobe |
| cfg_ctrl | input | 8 | Control byte: bit0 enable, bit1 automatic, bit7 manual request |
| cfg_delay | input | DLY_W | Pre-launch delay value D |
| clr_wr | input | 1 | Clear write strobe |
| clr_code | input | 8 | Clear code; 0xFF wipes the channel |
| brc_launch | output | 1 | Broadcast launch strobe |
| slot_win | output | NUM_SLOTS | One-hot capture window of the current slot |
| slot_pend | output | NUM_SLOTS | Slots still awaiting their response window |
| st_en | output | 1 | Collection enabled |
| st_auto | output | 1 | Automatic mode active |
| st_manual | output | 1 | Manual request outstanding |

## Verification
A corrupted delay or period counter moves the launch strobe away from its computed edge. The bench detects this at the very first launch, because it measures the exact edge count rather than a range. A wrong merge or self-clear decision shows up either as a second strobe within a few hundred cycles or as st_manual holding high past the strobe. A broken slot sequencer shows on slot_win or slot_pend within one SLOT_TICKS interval of the launch. A wrong write-gating decision shows on the status outputs in the very next cycle.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int CTRL_W   = 8;
  localparam int EN_BIT   = 0;
  localparam int AUTO_BIT = 1;
  localparam int MAN_BIT  = 7;
  localparam logic [CTRL_W-1:0] WIPE_CODE = 8'hFF;

  typedef struct packed {
    logic en;
    logic auto_on;
    logic man;
  } pbs_mode_t;
endpackage

// File: rtl/pbs_cfg_regs.sv
module pbs_cfg_regs
  import pbs_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              fire_now,
  output pbs_mode_t         mode_q,
  output logic [DLY_W-1:0]  dly_eff,
  output logic              man_req
);
  logic [DLY_W-1:0] dly_q;
  logic             auto_nxt;

  // Automatic bit is writable only when collection was already on.
  always_comb begin
    auto_nxt = mode_q.auto_on;
    if (cfg_wr && mode_q.en) auto_nxt = cfg_ctrl[AUTO_BIT];
    man_req = cfg_wr && mode_q.en && !auto_nxt && cfg_ctrl[MAN_BIT];
    dly_eff = cfg_wr ? cfg_delay : dly_q;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      mode_q <= '0;
      dly_q  <= '0;
    end else begin
      if (cfg_wr) begin
        dly_q <= cfg_delay;
        if (cfg_ctrl[EN_BIT]) mode_q.en <= 1'b1;
      end
      mode_q.auto_on <= auto_nxt;
      if (fire_now)     mode_q.man <= 1'b0;
      else if (man_req) mode_q.man <= 1'b1;
    end
  end
endmodule

// File: rtl/pbs_period_timer.sv
module pbs_period_timer #(
  parameter int PERIOD = 5000
) (
  input  logic clk,
  input  logic srst,
  input  logic tick,
  input  logic run,
  output logic hit
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt;

  assign hit = run && tick && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (srst || !run) cnt <= '0;
    else if (tick)    cnt <= hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pbs_launch_delay.sv
module pbs_launch_delay #(
  parameter int DLY_W = 8,
  parameter int STEP  = 5
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             fire_now,
  output logic             launch_q
);
  localparam int MAXV = ((1 << DLY_W) - 1) * STEP;
  localparam int CW   = $clog2(MAXV + 1);

  logic          pend;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load;

  assign load     = CW'(dly) * CW'(STEP);
  assign fire_now = pend && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (srst) begin
      pend     <= 1'b0;
      cnt      <= '0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= fire_now;
      if (fire_now)          pend <= 1'b0;
      else if (pend && tick) cnt  <= cnt - 1'b1;
      // A start while pending is absorbed by the launch already queued.
      if (start && !pend) begin
        pend <= 1'b1;
        cnt  <= load;
      end
    end
  end
endmodule

// File: rtl/pbs_slot_windows.sv
module pbs_slot_windows #(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_TICKS = 16
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 tick,
  input  logic                 start,
  output logic [NUM_SLOTS-1:0] win_q,
  output logic [NUM_SLOTS-1:0] pend_q
);
  localparam int SW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [SW-1:0]        scnt;
  logic                 active;
  logic                 adv;
  logic [NUM_SLOTS-1:0] shift_in;
  logic [NUM_SLOTS-1:0] win_nx;
  logic [NUM_SLOTS-1:0] pend_nx;

  assign active = |win_q;
  assign adv    = active && tick && (scnt == SW'(SLOT_TICKS - 1));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    if (k == 0) begin : g_first
      assign shift_in[k] = 1'b0;
    end else begin : g_next
      assign shift_in[k] = win_q[k-1];
    end
    assign win_nx[k]  = start ? (k == 0) : (adv ? shift_in[k] : win_q[k]);
    assign pend_nx[k] = start ? 1'b1 : ((adv && win_q[k]) ? 1'b0 : pend_q[k]);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      win_q  <= '0;
      pend_q <= '0;
      scnt   <= '0;
    end else begin
      win_q  <= win_nx;
      pend_q <= pend_nx;
      if (start)                scnt <= '0;
      else if (active && tick)  scnt <= adv ? '0 : scnt + 1'b1;
    end
  end
endmodule

// File: rtl/pbs_brc_scheduler.sv
module pbs_brc_scheduler
  import pbs_pkg::*;
#(
  parameter int PERIOD_TICKS = 5000,
  parameter int DLY_W        = 8,
  parameter int DLY_STEP     = 5,
  parameter int NUM_SLOTS    = 4,
  parameter int SLOT_TICKS   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 cfg_wr,
  input  logic [7:0]           cfg_ctrl,
  input  logic [DLY_W-1:0]     cfg_delay,
  input  logic                 clr_wr,
  input  logic [7:0]           clr_code,
  output logic                 brc_launch,
  output logic [NUM_SLOTS-1:0] slot_win,
  output logic [NUM_SLOTS-1:0] slot_pend,
  output logic                 st_en,
  output logic                 st_auto,
  output logic                 st_manual
);
  logic             srst;
  pbs_mode_t        mode;
  logic [DLY_W-1:0] dly_eff;
  logic             man_req;
  logic             period_hit;
  logic             fire_now;

  assign srst = rst || (clr_wr && (clr_code == WIPE_CODE));

  pbs_cfg_regs #(.DLY_W(DLY_W)) u_cfg (
    .clk(clk), .srst(srst), .cfg_wr(cfg_wr), .cfg_ctrl(cfg_ctrl),
    .cfg_delay(cfg_delay), .fire_now(fire_now), .mode_q(mode),
    .dly_eff(dly_eff), .man_req(man_req)
  );

  pbs_period_timer #(.PERIOD(PERIOD_TICKS)) u_per (
    .clk(clk), .srst(srst), .tick(tick), .run(mode.auto_on), .hit(period_hit)
  );

  pbs_launch_delay #(.DLY_W(DLY_W), .STEP(DLY_STEP)) u_dly (
    .clk(clk), .srst(srst), .tick(tick), .start(man_req || period_hit),
    .dly(dly_eff), .fire_now(fire_now), .launch_q(brc_launch)
  );

  pbs_slot_windows #(.NUM_SLOTS(NUM_SLOTS), .SLOT_TICKS(SLOT_TICKS)) u_win (
    .clk(clk), .srst(srst), .tick(tick), .start(fire_now),
    .win_q(slot_win), .pend_q(slot_pend)
  );

  assign st_en     = mode.en;
  assign st_auto   = mode.auto_on;
  assign st_manual = mode.man;
endmodule

// File: rtl/pbs_brc_scheduler_chk.sv
module pbs_brc_scheduler_chk
  import pbs_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_wr,
  input logic                 clr_wr,
  input logic [7:0]           clr_code,
  input logic                 brc_launch,
  input logic [NUM_SLOTS-1:0] slot_win,
  input logic [NUM_SLOTS-1:0] slot_pend,
  input logic                 st_en,
  input logic                 st_auto,
  input logic                 st_manual
);
  // R2
  en_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st_en) |-> $past(clr_wr && (clr_code == WIPE_CODE)));
  // R3
  auto_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_auto) |-> $past(st_en));
  // R4
  man_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_manual) |-> $past(st_en && cfg_wr));
  // R4
  man_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st_manual) |-> (brc_launch || $past(clr_wr && (clr_code == WIPE_CODE))));
  // R2
  launch_en_chk: assert property (@(posedge clk) disable iff (rst)
    brc_launch |-> st_en);
  // R8
  launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    brc_launch |=> !brc_launch);
  // R9
  win_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_win));
  // R9
  launch_win_chk: assert property (@(posedge clk) disable iff (rst)
    brc_launch |-> (slot_win[0] && (&slot_pend)));
  // R9
  win_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_win & ~slot_pend) == '0);
endmodule

bind pbs_brc_scheduler pbs_brc_scheduler_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .clr_wr(clr_wr), .clr_code(clr_code),
  .brc_launch(brc_launch), .slot_win(slot_win), .slot_pend(slot_pend),
  .st_en(st_en), .st_auto(st_auto), .st_manual(st_manual)
);

// File: tb/pbs_brc_scheduler_tb.sv
module pbs_brc_scheduler_tb;
  localparam int PER = 5000;
  localparam int ST  = 16;
  localparam int NS  = 4;
  localparam logic [7:0] C_EN = 8'h01, C_AUTO = 8'h02, C_MAN = 8'h80;
  // {delay, expected edges from accepting write to launch}
  localparam logic [19:0] VEC [6] = '{
    {8'd0, 12'd1}, {8'd1, 12'd6}, {8'd3, 12'd16},
    {8'd10, 12'd51}, {8'd51, 12'd256}, {8'd255, 12'd1276}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1;
  logic cfg_wr = 1'b0, clr_wr = 1'b0;
  logic [7:0] cfg_ctrl = '0, cfg_delay = '0, clr_code = '0;
  logic brc_launch, st_en, st_auto, st_manual;
  logic [NS-1:0] slot_win, slot_pend;
  int total = 0, bad = 0;
  int k;

  always #5 clk = ~clk;

  pbs_brc_scheduler u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_wr(cfg_wr), .cfg_ctrl(cfg_ctrl),
    .cfg_delay(cfg_delay), .clr_wr(clr_wr), .clr_code(clr_code),
    .brc_launch(brc_launch), .slot_win(slot_win), .slot_pend(slot_pend),
    .st_en(st_en), .st_auto(st_auto), .st_manual(st_manual)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_ctrl(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_ctrl = c; cfg_delay = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr_clr(input logic [7:0] c);
    @(negedge clk); clr_wr = 1'b1; clr_code = c;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  task automatic count_launch(input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); @(negedge clk);
      if (brc_launch) begin n = i; break; end
    end
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(10 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    adv(3); rst = 1'b0; adv(1);
    // R1 reset state
    chk("R1 launch", brc_launch, 0);
    chk("R1 win", slot_win, 0);
    chk("R1 pend", slot_pend, 0);
    chk("R1 status", {st_en, st_auto, st_manual}, 0);

    // R3 auto ignored while disabled; R4 manual ignored while disabled
    wr_ctrl(C_AUTO, 8'd0);
    chk("R3 auto gated", st_auto, 0);
    wr_ctrl(C_MAN, 8'd2);
    chk("R4 manual gated", st_manual, 0);
    count_launch(50, k);
    chk("R4 no launch when off", k, -1);

    // R2 enable semantics
    wr_ctrl(C_EN, 8'd0);
    chk("R2 enable on", st_en, 1);
    wr_ctrl(8'h00, 8'd0);
    chk("R2 zero write keeps enable", st_en, 1);
    wr_clr(8'h55);
    chk("R2 other clear code ignored", st_en, 1);

    // R5 vector walk over delay values
    for (int i = 0; i < 6; i++) begin
      wr_ctrl(C_EN | C_MAN, VEC[i][19:12]);
      chk("R4 manual pending", st_manual, 1);
      count_launch(2000, k);
      chk("R5 launch edge", k, int'(VEC[i][11:0]));
      chk("R4 self clear", st_manual, 0);
      adv(1);
      chk("R8 one cycle strobe", brc_launch, 0);
    end

    // R9 slot windows
    wr_ctrl(C_EN | C_MAN, 8'd2);
    count_launch(100, k);
    chk("R9 launch win", slot_win, 4'b0001);
    chk("R9 launch pend", slot_pend, 4'b1111);
    adv(ST - 1);
    chk("R9 slot0 still open", slot_win, 4'b0001);
    adv(1);
    chk("R9 slot1 win", slot_win, 4'b0010);
    chk("R9 slot0 done", slot_pend, 4'b1110);
    adv(3 * ST);
    chk("R9 all done win", slot_win, 0);
    chk("R9 all done pend", slot_pend, 0);

    // R6 merge of a second manual request
    wr_ctrl(C_EN | C_MAN, 8'd10);
    adv(20);
    wr_ctrl(C_EN | C_MAN, 8'd10);
    count_launch(200, k);
    chk("R6 merged launch edge", k, 29);
    count_launch(200, k);
    chk("R6 no second launch", k, -1);

    // R10 tick gating
    tick = 1'b0;
    wr_ctrl(C_EN | C_MAN, 8'd0);
    count_launch(20, k);
    chk("R10 held without tick", k, -1);
    tick = 1'b1;
    count_launch(3, k);
    chk("R10 launch on tick", k, 1);

    // R11 clear cancels pending launch
    wr_ctrl(C_EN | C_MAN, 8'd20);
    adv(10);
    wr_clr(8'hFF);
    chk("R2 clear disables", st_en, 0);
    chk("R11 clear drops request", st_manual, 0);
    count_launch(200, k);
    chk("R11 cancelled launch", k, -1);

    // R7 automatic mode
    wr_ctrl(C_EN, 8'd4);
    wr_ctrl(C_EN | C_AUTO, 8'd4);
    chk("R3 auto accepted", st_auto, 1);
    count_launch(6000, k);
    chk("R7 first auto launch", k, PER + 21);
    chk("R9 auto launch win", slot_win, 4'b0001);
    count_launch(6000, k);
    chk("R7 auto interval", k, PER);
    wr_ctrl(C_EN | C_AUTO | C_MAN, 8'd4);
    chk("R4 manual ignored in auto", st_manual, 0);
    wr_ctrl(C_EN, 8'd4);
    chk("R3 auto off", st_auto, 0);
    count_launch(PER + 100, k);
    chk("R7 stopped", k, -1);
    wr_clr(8'hFF);
    chk("R2 wipe status", {st_en, st_auto, st_manual}, 0);

    summary();
    $finish;
  end
endmodule